// File: doc/BRIEF.md
# CPU Register Snoop and Reconstruction Unit

This block recovers the programmer-visible registers of an 8/16-bit CPU that has no debug access of its own. A debug controller forces a fixed, position-independent instruction sequence into the CPU at opcode-fetch time: push flags, pull flags, store accumulator to direct page, store X to an absolute address, store Y to direct page, then branch back. The stores are blocked from reaching memory. While the sequence runs, this unit watches the CPU bus one CPU cycle at a time. It works out which cycle of which instruction carries each register value on the address, bank or data lines, and latches that value.

The unit counts opcode fetches and write cycles from the moment `start` is pulsed. From that count it picks out the following values:
- the program counter with its bank, from the first fetch;
- the stack pointer and the flags, from the push write;
- the accumulator low byte and the direct page register, from the first store;
- the X low byte and the data bank, from the second store;
- the Y low byte, from the third store;
- the optional extra write that each store makes when its register is 16 bits wide.

The emulation, memory-width and index-width pins are latched together with the program counter. The results appear on parallel outputs. A `valid` flag marks the moment the last store has been seen.

Top module: `regsnoop`

## Requirements
- R1: While `rst_n` is low and after reset, `valid` is 0 and every register output, including the mode outputs, is 0.
- R2: A `start` pulse clears `valid` and all register outputs on the next clock edge. It rearms the decoder so that the next qualified fetch is treated as the first instruction. Bus inputs in the start cycle are ignored.
- R3: `pc` equals `{bank, addr}` from the first cycle after `start` with `cyc_en`=1 and `fetch`=1. `mode_e`, `mode_m` and `mode_x` equal `pin_e`, `pin_m` and `pin_x` sampled in that same cycle.
- R4: `flags` equals `data` on the first write cycle (`rw`=0) of the first instruction. `sp` equals `addr` of that cycle when `mode_e`=0. When `mode_e`=1, `sp` equals 0x01 in the high byte and the low byte of `addr`.
- R5: `acc[7:0]` is the data of the first write of the third instruction, and `acc[15:8]` is the data of its second write. `acc[15:8]` stays 0 when that second write does not occur, which is the case in emulation mode or when M=1.
- R6: X and Y are the write data of the fourth and fifth instruction. Their first write gives the low byte and an optional second write gives the high byte. The high bytes stay 0 when not observed, which is the case in emulation mode or when X=1.
- R7: `dpr` equals the `addr` of the third instruction's first write minus 2, modulo 2^16.
- R8: `dbr` equals `bank` during the fourth instruction's first write when `mode_e`=0, and is 0 when `mode_e`=1.
- R9: Cycles with `cyc_en`=0 are ignored entirely.
- R10: `valid` rises on the clock edge that captures the final store write. That write is the fifth instruction's second write when `mode_e`=0 and `mode_x`=0, and its first write otherwise. After that, bus activity changes no output until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new snoop; clears results |
| cyc_en | input | 1 | One-clock qualifier marking a completed CPU bus cycle |
| fetch | input | 1 | Cycle is an opcode fetch |
| rw | input | 1 | 1 = read cycle, 0 = write cycle |
| addr | input | 16 | CPU address bus |
| bank | input | 8 | CPU bank address |
| data | input | 8 | CPU data bus |
| pin_e | input | 1 | Emulation-mode pin |
| pin_m | input | 1 | Memory/accumulator width pin (1 = 8 bit) |
| pin_x | input | 1 | Index width pin (1 = 8 bit) |
| pc | output | 24 | Program counter with bank |
| sp | output | 16 | Stack pointer |
| flags | output | 8 | Processor flags |
| acc | output | 16 | Accumulator |
| xr | output | 16 | X index |
| yr | output | 16 | Y index |
| dpr | output | 16 | Direct page register |
| dbr | output | 8 | Data bank register |
| mode_e | output | 1 | Latched emulation pin |
| mode_m | output | 1 | Latched memory-width pin |
| mode_x | output | 1 | Latched index-width pin |
| valid | output | 1 | All registers captured |

## Verification
A slip in the instruction or write counter shows at the ports as a value stored into the wrong register field. For example, the X data may turn up in `acc`, or the direct page may be taken from another store address. This is visible as soon as `valid` rises, a single clock after the last store write. A latched mode bit that is wrong shows up in the same way. The high bytes or `dbr` become nonzero where they must be 0, or `valid` rises one write too early or too late. The sequences cover emulation mode, native 16-bit mode and mixed widths, idle cycles that carry write-like bus values, and a direct page value that wraps around 2^16.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

    // which register field the current bus cycle carries
    typedef enum logic [3:0] {
        SL_NONE,
        SL_PC,
        SL_SPF,
        SL_ALO,
        SL_AHI,
        SL_XLO,
        SL_XHI,
        SL_YLO,
        SL_YHI
    } slot_e;

    // position of each instruction in the forced sequence (order is behaviour)
    localparam int unsigned IDX_PUSH = 0;
    localparam int unsigned IDX_PULL = 1;
    localparam int unsigned IDX_STA  = 2;
    localparam int unsigned IDX_STX  = 3;
    localparam int unsigned IDX_STY  = 4;

endpackage

// File: rtl/snoop_phase.sv
module snoop_phase
    import snoop_pkg::*;
#(
    parameter int unsigned IDX_W  = 3,
    parameter int unsigned WCNT_W = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  logic  cyc_en,
    input  logic  fetch,
    input  logic  rw,
    input  logic  wide_idx,
    output slot_e slot,
    output logic  done
);
    localparam logic [IDX_W-1:0]  IDX_MAX  = {IDX_W{1'b1}};
    localparam logic [WCNT_W-1:0] WCNT_MAX = {WCNT_W{1'b1}};

    typedef struct packed {
        logic              armed;
        logic              seen;
        logic [IDX_W-1:0]  idx;
        logic [WCNT_W-1:0] wcnt;
    } ph_t;

    ph_t ph_d, ph_q;

    always_comb begin
        ph_d = ph_q;
        slot = SL_NONE;
        done = 1'b0;
        if (start) begin
            ph_d.armed = 1'b1;
            ph_d.seen  = 1'b0;
            ph_d.idx   = '0;
            ph_d.wcnt  = '0;
        end else if (ph_q.armed && cyc_en) begin
            if (fetch) begin
                if (!ph_q.seen) begin
                    slot       = SL_PC;
                    ph_d.seen  = 1'b1;
                    ph_d.idx   = '0;
                end else if (ph_q.idx != IDX_MAX) begin
                    ph_d.idx = ph_q.idx + 1'b1;
                end
                ph_d.wcnt = '0;
            end else if (!rw && ph_q.seen) begin
                case (ph_q.idx)
                    IDX_W'(IDX_PUSH): slot = (ph_q.wcnt == '0) ? SL_SPF : SL_NONE;
                    IDX_W'(IDX_STA): begin
                        if (ph_q.wcnt == WCNT_W'(0))      slot = SL_ALO;
                        else if (ph_q.wcnt == WCNT_W'(1)) slot = SL_AHI;
                    end
                    IDX_W'(IDX_STX): begin
                        if (ph_q.wcnt == WCNT_W'(0))      slot = SL_XLO;
                        else if (ph_q.wcnt == WCNT_W'(1)) slot = SL_XHI;
                    end
                    IDX_W'(IDX_STY): begin
                        if (ph_q.wcnt == WCNT_W'(0))      slot = SL_YLO;
                        else if (ph_q.wcnt == WCNT_W'(1)) slot = SL_YHI;
                    end
                    default: slot = SL_NONE;
                endcase
                if (ph_q.wcnt != WCNT_MAX) ph_d.wcnt = ph_q.wcnt + 1'b1;
            end
            done = (slot == SL_YHI) || (slot == SL_YLO && !wide_idx);
            if (done) ph_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= '0;
        else        ph_q <= ph_d;
    end

endmodule

// File: rtl/snoop_capture.sv
module snoop_capture
    import snoop_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned BANK_W    = 8,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned DP_OFFSET = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  slot_e                    slot,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [BANK_W-1:0]        bank,
    input  logic [DATA_W-1:0]        data,
    input  logic                     pin_e,
    input  logic                     pin_m,
    input  logic                     pin_x,
    output logic [BANK_W+ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0]        sp,
    output logic [DATA_W-1:0]        flags,
    output logic [2*DATA_W-1:0]      acc,
    output logic [2*DATA_W-1:0]      xr,
    output logic [2*DATA_W-1:0]      yr,
    output logic [ADDR_W-1:0]        dpr,
    output logic [BANK_W-1:0]        dbr,
    output logic                     mode_e,
    output logic                     mode_m,
    output logic                     mode_x,
    output logic                     wide_idx
);
    localparam int unsigned WIDE_W = 2 * DATA_W;
    localparam int unsigned PAD_W  = ADDR_W - DATA_W - 1;
    localparam logic [ADDR_W-1:0] DP_SUB = ADDR_W'(DP_OFFSET);

    typedef struct packed {
        logic [BANK_W+ADDR_W-1:0] pc;
        logic [ADDR_W-1:0]        sp;
        logic [DATA_W-1:0]        fl;
        logic [WIDE_W-1:0]        a;
        logic [WIDE_W-1:0]        x;
        logic [WIDE_W-1:0]        y;
        logic [ADDR_W-1:0]        d;
        logic [BANK_W-1:0]        db;
        logic                     e;
        logic                     m;
        logic                     xf;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (start) begin
            cap_d = '0;
        end else begin
            case (slot)
                SL_PC: begin
                    cap_d.pc = {bank, addr};
                    cap_d.e  = pin_e;
                    cap_d.m  = pin_m;
                    cap_d.xf = pin_x;
                end
                SL_SPF: begin
                    cap_d.fl = data;
                    if (cap_q.e) cap_d.sp = {{PAD_W{1'b0}}, 1'b1, addr[DATA_W-1:0]};
                    else         cap_d.sp = addr;
                end
                SL_ALO: begin
                    cap_d.a[DATA_W-1:0] = data;
                    cap_d.d             = addr - DP_SUB;
                end
                SL_AHI: cap_d.a[WIDE_W-1:DATA_W] = data;
                SL_XLO: begin
                    cap_d.x[DATA_W-1:0] = data;
                    cap_d.db            = cap_q.e ? '0 : bank;
                end
                SL_XHI: cap_d.x[WIDE_W-1:DATA_W] = data;
                SL_YLO: cap_d.y[DATA_W-1:0]      = data;
                SL_YHI: cap_d.y[WIDE_W-1:DATA_W] = data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign pc       = cap_q.pc;
    assign sp       = cap_q.sp;
    assign flags    = cap_q.fl;
    assign acc      = cap_q.a;
    assign xr       = cap_q.x;
    assign yr       = cap_q.y;
    assign dpr      = cap_q.d;
    assign dbr      = cap_q.db;
    assign mode_e   = cap_q.e;
    assign mode_m   = cap_q.m;
    assign mode_x   = cap_q.xf;
    assign wide_idx = !cap_q.e && !cap_q.xf;

endmodule

// File: rtl/regsnoop.sv
module regsnoop
    import snoop_pkg::*;
#(
    parameter int unsigned ADDR_W    = 16,
    parameter int unsigned BANK_W    = 8,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned DP_OFFSET = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     cyc_en,
    input  logic                     fetch,
    input  logic                     rw,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [BANK_W-1:0]        bank,
    input  logic [DATA_W-1:0]        data,
    input  logic                     pin_e,
    input  logic                     pin_m,
    input  logic                     pin_x,
    output logic [BANK_W+ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0]        sp,
    output logic [DATA_W-1:0]        flags,
    output logic [2*DATA_W-1:0]      acc,
    output logic [2*DATA_W-1:0]      xr,
    output logic [2*DATA_W-1:0]      yr,
    output logic [ADDR_W-1:0]        dpr,
    output logic [BANK_W-1:0]        dbr,
    output logic                     mode_e,
    output logic                     mode_m,
    output logic                     mode_x,
    output logic                     valid
);
    localparam int unsigned IDX_W  = 3;
    localparam int unsigned WCNT_W = 2;

    slot_e slot;
    logic  done;
    logic  wide_idx;

    typedef struct packed {
        logic valid;
    } top_t;

    top_t top_d, top_q;

    snoop_phase #(
        .IDX_W (IDX_W),
        .WCNT_W(WCNT_W)
    ) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .cyc_en  (cyc_en),
        .fetch   (fetch),
        .rw      (rw),
        .wide_idx(wide_idx),
        .slot    (slot),
        .done    (done)
    );

    snoop_capture #(
        .ADDR_W   (ADDR_W),
        .BANK_W   (BANK_W),
        .DATA_W   (DATA_W),
        .DP_OFFSET(DP_OFFSET)
    ) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .slot    (slot),
        .addr    (addr),
        .bank    (bank),
        .data    (data),
        .pin_e   (pin_e),
        .pin_m   (pin_m),
        .pin_x   (pin_x),
        .pc      (pc),
        .sp      (sp),
        .flags   (flags),
        .acc     (acc),
        .xr      (xr),
        .yr      (yr),
        .dpr     (dpr),
        .dbr     (dbr),
        .mode_e  (mode_e),
        .mode_m  (mode_m),
        .mode_x  (mode_x),
        .wide_idx(wide_idx)
    );

    always_comb begin
        top_d = top_q;
        if (start)     top_d.valid = 1'b0;
        else if (done) top_d.valid = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign valid = top_q.valid;

endmodule

// File: rtl/regsnoop_chk.sv
module regsnoop_chk #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned BANK_W = 8,
    parameter int unsigned DATA_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start,
    input logic                     cyc_en,
    input logic [BANK_W+ADDR_W-1:0] pc,
    input logic [ADDR_W-1:0]        sp,
    input logic [2*DATA_W-1:0]      acc,
    input logic [2*DATA_W-1:0]      xr,
    input logic [2*DATA_W-1:0]      yr,
    input logic [BANK_W-1:0]        dbr,
    input logic                     mode_e,
    input logic                     mode_m,
    input logic                     mode_x,
    input logic                     valid
);
    a_r2_start_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !valid);

    a_r10_valid_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !start) |=> valid);

    a_r10_frozen_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !start) |=> ($stable(pc) && $stable(sp) && $stable(acc) && $stable(xr) && $stable(yr)));

    a_r9_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_en && !start) |=> ($stable(acc) && $stable(xr) && $stable(yr) && $stable(valid)));

    a_r4_sp_page_one: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && mode_e) |-> (sp[ADDR_W-1:DATA_W] == 1));

    a_r5_acc_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (mode_e || mode_m)) |-> (acc[2*DATA_W-1:DATA_W] == '0));

    a_r6_index_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (mode_e || mode_x)) |-> (xr[2*DATA_W-1:DATA_W] == '0 && yr[2*DATA_W-1:DATA_W] == '0));

    a_r8_dbr_zero_emul: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && mode_e) |-> (dbr == '0));

endmodule

bind regsnoop regsnoop_chk #(
    .ADDR_W(ADDR_W),
    .BANK_W(BANK_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .cyc_en(cyc_en),
    .pc    (pc),
    .sp    (sp),
    .acc   (acc),
    .xr    (xr),
    .yr    (yr),
    .dbr   (dbr),
    .mode_e(mode_e),
    .mode_m(mode_m),
    .mode_x(mode_x),
    .valid (valid)
);

// File: tb/sim_regsnoop.sv
module sim_regsnoop;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cyc_en = 1'b0;
    logic        fetch = 1'b0;
    logic        rw = 1'b1;
    logic [15:0] addr = '0;
    logic [7:0]  bank = '0;
    logic [7:0]  data = '0;
    logic        pin_e = 1'b0;
    logic        pin_m = 1'b0;
    logic        pin_x = 1'b0;
    logic [23:0] pc;
    logic [15:0] sp, acc, xr, yr, dpr;
    logic [7:0]  flags, dbr;
    logic        mode_e, mode_m, mode_x, valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit wd_hit = 1'b0;

    always #4 clk = ~clk;

    regsnoop u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cyc_en(cyc_en), .fetch(fetch),
        .rw(rw), .addr(addr), .bank(bank), .data(data), .pin_e(pin_e),
        .pin_m(pin_m), .pin_x(pin_x), .pc(pc), .sp(sp), .flags(flags),
        .acc(acc), .xr(xr), .yr(yr), .dpr(dpr), .dbr(dbr), .mode_e(mode_e),
        .mode_m(mode_m), .mode_x(mode_x), .valid(valid)
    );

    typedef struct packed {
        logic        e, m, x;
        logic [23:0] pc;
        logic [15:0] sp;
        logic [7:0]  fl;
        logic [15:0] a, xv, yv, d;
        logic [7:0]  db;
    } vec_t;

    localparam int NV = 4;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 1'b1, 24'h00C123, 16'h01E9, 8'h34, 16'h1203, 16'h5644, 16'h9A55, 16'h0000, 8'h7F},
        '{1'b0, 1'b0, 1'b0, 24'h128000, 16'h1FF0, 8'h00, 16'hBEEF, 16'h1234, 16'hCAFE, 16'h2100, 8'h7E},
        '{1'b0, 1'b1, 1'b0, 24'h3FFFFE, 16'h0100, 8'h20, 16'h55AA, 16'h0F0E, 16'h0D0C, 16'hFFFF, 8'h01},
        '{1'b0, 1'b0, 1'b1, 24'h000000, 16'h7FFF, 8'h10, 16'h8001, 16'h4321, 16'h8765, 16'h0080, 8'h00}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // one bus cycle; results are sampled 1 ns after the capturing edge
    task automatic cyc(input logic en, input logic f, input logic r, input logic [15:0] a,
                       input logic [7:0] b, input logic [7:0] d);
        @(negedge clk);
        cyc_en = en; fetch = f; rw = r; addr = a; bank = b; data = d;
        @(posedge clk);
        #1;
        cyc_en = 1'b0; start = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        cyc_en = 1'b1; fetch = 1'b1; rw = 1'b0; addr = 16'hDEAD; data = 8'h99;
        @(posedge clk);
        #1;
        start = 1'b0; cyc_en = 1'b0;
    endtask

    task automatic run_vec(input vec_t v, input int k);
        logic        wa, wi;
        logic [15:0] pa;
        logic [7:0]  pb;
        wa = !v.e && !v.m;
        wi = !v.e && !v.x;
        pa = v.pc[15:0];
        pb = v.pc[23:16];
        pin_e = v.e; pin_m = v.m; pin_x = v.x;
        pulse_start();
        chk("R2", "valid after start", {31'b0, valid}, 32'd0);
        chk("R2", "acc cleared by start", {16'b0, acc}, 32'd0);
        // push flags
        cyc(1, 1, 1, pa, pb, 8'h08);
        cyc(0, 0, 0, 16'h0002, 8'hEE, 8'h77);      // R9 idle cycle with write-like values
        cyc(1, 0, 1, pa + 16'd1, pb, 8'h00);
        cyc(1, 0, 0, v.sp, 8'h00, v.fl);
        // pull flags
        cyc(1, 1, 1, pa + 16'd1, pb, 8'h28);
        cyc(1, 0, 1, pa + 16'd2, pb, 8'h00);
        cyc(1, 0, 1, v.sp, 8'h00, 8'h00);
        cyc(1, 0, 1, v.sp, 8'h00, v.fl);
        // store accumulator, direct page
        cyc(1, 1, 1, pa + 16'd2, pb, 8'h85);
        cyc(1, 0, 1, pa + 16'd3, pb, 8'h02);
        cyc(1, 0, 0, v.d + 16'd2, 8'h00, v.a[7:0]);
        if (wa) cyc(1, 0, 0, v.d + 16'd3, 8'h00, v.a[15:8]);
        // store X, absolute
        cyc(1, 1, 1, pa + 16'd4, pb, 8'h8E);
        cyc(1, 0, 1, pa + 16'd5, pb, 8'h40);
        cyc(1, 0, 1, pa + 16'd6, pb, 8'h44);
        cyc(1, 0, 0, 16'h4440, v.db, v.xv[7:0]);
        if (wi) cyc(1, 0, 0, 16'h4441, v.db, v.xv[15:8]);
        // store Y, direct page
        cyc(1, 1, 1, pa + 16'd7, pb, 8'h84);
        cyc(1, 0, 1, pa + 16'd8, pb, 8'h06);
        cyc(1, 0, 0, v.d + 16'd6, 8'h00, v.yv[7:0]);
        if (wi) begin
            chk("R10", $sformatf("v%0d valid before high Y write", k), {31'b0, valid}, 32'd0);
            cyc(1, 0, 0, v.d + 16'd7, 8'h00, v.yv[15:8]);
        end
        chk("R10", $sformatf("v%0d valid after final store", k), {31'b0, valid}, 32'd1);
        // branch back plus trailing activity that must be ignored
        cyc(1, 1, 1, pa + 16'd9, pb, 8'h80);
        cyc(1, 0, 0, 16'h0055, 8'h33, 8'hA5);
        cyc(1, 1, 1, 16'h1111, 8'h22, 8'hEA);
        cyc(1, 0, 0, 16'h2222, 8'h44, 8'h5A);
        chk("R3", $sformatf("v%0d pc", k), {8'b0, pc}, {8'b0, v.pc});
        chk("R3", $sformatf("v%0d modes", k), {29'b0, mode_e, mode_m, mode_x}, {29'b0, v.e, v.m, v.x});
        chk("R4", $sformatf("v%0d flags", k), {24'b0, flags}, {24'b0, v.fl});
        chk("R4", $sformatf("v%0d sp", k), {16'b0, sp}, v.e ? {16'b0, 8'h01, v.sp[7:0]} : {16'b0, v.sp});
        chk("R5", $sformatf("v%0d acc", k), {16'b0, acc}, wa ? {16'b0, v.a} : {24'b0, v.a[7:0]});
        chk("R6", $sformatf("v%0d x", k), {16'b0, xr}, wi ? {16'b0, v.xv} : {24'b0, v.xv[7:0]});
        chk("R6", $sformatf("v%0d y", k), {16'b0, yr}, wi ? {16'b0, v.yv} : {24'b0, v.yv[7:0]});
        chk("R7", $sformatf("v%0d dpr", k), {16'b0, dpr}, {16'b0, v.d});
        chk("R8", $sformatf("v%0d dbr", k), {24'b0, dbr}, v.e ? 32'd0 : {24'b0, v.db});
        chk("R10", $sformatf("v%0d valid holds", k), {31'b0, valid}, 32'd1);
    endtask

    initial begin
        #1_000_000;
        wd_hit = 1'b1;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state, with bus activity during reset
        cyc(1, 1, 1, 16'h1234, 8'h56, 8'h78);
        chk("R1", "valid in reset", {31'b0, valid}, 32'd0);
        chk("R1", "pc in reset", {8'b0, pc}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", "valid after reset", {31'b0, valid}, 32'd0);
        chk("R1", "regs after reset", {sp, acc}, 32'd0);
        chk("R1", "modes after reset", {29'b0, mode_e, mode_m, mode_x}, 32'd0);
        // R9: not armed yet, so a fetch must not capture pc
        cyc(1, 1, 1, 16'hAAAA, 8'h11, 8'h00);
        chk("R9", "no capture before start", {8'b0, pc}, 32'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R2: a new start clears a valid result and its registers
        pulse_start();
        chk("R2", "valid cleared by restart", {31'b0, valid}, 32'd0);
        chk("R2", "pc cleared by restart", {8'b0, pc}, 32'd0);
        // R9: a qualified fetch after idle cycles is still the first instruction
        cyc(0, 1, 1, 16'h9999, 8'h09, 8'h00);
        cyc(1, 1, 1, 16'h4567, 8'h02, 8'h08);
        chk("R3", "first fetch after idle", {8'b0, pc}, 32'h00024567);
        // R1: reset mid-sequence
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R1", "reset mid-run pc", {8'b0, pc}, 32'd0);
        rst_n = 1'b1;

        if (!wd_hit) begin
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule